// File: doc/BRIEF.md
# Parallel Read Master with Wait-State Stretch

This block runs read transfers on a generic parallel bus on behalf of internal logic. A one-clock read command starts a transfer. The master then raises its request line and counts a fixed access window in system clocks. At the last clock of that window it looks at the slave's wait line. If the wait line is low, the slave is fast: the master latches the data pins on that clock and drops the request.

If the wait line is high at that clock, the slave is slow. The master keeps the request up until the first clock on which the wait line is low, and latches the data on that clock. A slave that never releases the line is cut off after a bounded number of stall clocks. In that case the master drops the request and reports a bus error instead of data.

Internal logic receives the latched word together with a one-clock valid strobe for each completed read.

Top module: `par_read_master`

## Requirements
- R1: When no request is active, a high `cmd_read` at a rising clock edge raises `bus_req` after that edge.
- R2: `bus_wait` is sampled only at the ACCESS_CYC-th rising edge after `bus_req` rises. If it is low there, the data pins are captured at that edge and `bus_req` falls, so `bus_req` stays high for exactly ACCESS_CYC clocks.
- R3: `rd_data` takes the value on `bus_data` at the capture edge and holds it until the next capture.
- R4: `rd_valid` is high for exactly one clock after each capture edge. It is never high together with `bus_err`.
- R5: A `bus_wait` pulse that ends before the sampling edge has no effect on timing or data. `bus_wait` has no effect while `bus_req` is low.
- R6: If `bus_wait` is high at the sampling edge, `bus_req` stays high and the capture happens at the first later edge at which `bus_wait` is low.
- R7: The capture of R6 may happen as late as the MAX_WAIT-th edge after the sampling edge. If `bus_wait` is still high at that edge, `bus_req` falls after it, `bus_err` pulses for one clock, `rd_valid` stays low and `rd_data` is unchanged.
- R8: `cmd_read` is ignored while `bus_req` is high. A command that arrives while `bus_req` is high starts no later transfer.
- R9: While `rst_n` is low, `bus_req`, `rd_valid`, `bus_err` and `rd_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_read | input | 1 | Read command from internal logic |
| rd_data | output | DATA_W | Last word captured from the bus |
| rd_valid | output | 1 | One-clock strobe: `rd_data` was just updated |
| bus_err | output | 1 | One-clock strobe: the stall limit was hit |
| bus_req | output | 1 | Request line to the slave |
| bus_wait | input | 1 | Wait line from the slave |
| bus_data | input | DATA_W | Data pins from the slave |

## Verification
The bench builds the block with ACCESS_CYC = 3, MAX_WAIT = 5 and DATA_W = 8. With these values the access window is short enough that a wait pulse can rise and fall entirely inside it. The stall limit is also small, so both a release on exactly the last allowed edge and a true timeout fit into a few dozen clocks. The short window also lets a command arrive mid-transfer, and lets commands run back to back.

// File: rtl/par_read_master.sv
module par_read_master #(
  parameter int DATA_W     = 8,
  parameter int ACCESS_CYC = 4,
  parameter int MAX_WAIT   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_read,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              bus_err,
  output logic              bus_req,
  input  logic              bus_wait,
  input  logic [DATA_W-1:0] bus_data
);

  localparam int AC_W = $clog2(ACCESS_CYC + 1);
  localparam int WT_W = $clog2(MAX_WAIT + 1);
  localparam logic [AC_W-1:0] AC_LAST = AC_W'(ACCESS_CYC - 1);
  localparam logic [WT_W-1:0] WT_LAST = WT_W'(MAX_WAIT - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ACCESS, ST_STALL} state_t;

  state_t          state;
  logic [AC_W-1:0] acc_cnt;
  logic [WT_W-1:0] wt_cnt;

  assign bus_req = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      acc_cnt  <= '0;
      wt_cnt   <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      bus_err  <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      bus_err  <= 1'b0;
      case (state)
        ST_IDLE: if (cmd_read) begin
          state   <= ST_ACCESS;
          acc_cnt <= '0;
        end
        ST_ACCESS: if (acc_cnt == AC_LAST) begin
          if (bus_wait) begin
            state  <= ST_STALL;
            wt_cnt <= '0;
          end else begin
            rd_data  <= bus_data;
            rd_valid <= 1'b1;
            state    <= ST_IDLE;
          end
        end else begin
          acc_cnt <= acc_cnt + 1'b1;
        end
        ST_STALL: if (!bus_wait) begin
          rd_data  <= bus_data;
          rd_valid <= 1'b1;
          state    <= ST_IDLE;
        end else if (wt_cnt == WT_LAST) begin
          bus_err <= 1'b1;
          state   <= ST_IDLE;
        end else begin
          wt_cnt <= wt_cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1
  req_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(cmd_read));

  // R2
  req_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> (rd_valid || bus_err));

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R4
  valid_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && bus_err));

  // R7
  err_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $stable(rd_data));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STALL && bus_wait && wt_cnt != WT_LAST) |=> bus_req);

endmodule

// File: tb/sim_par_read_master.sv
module sim_par_read_master;
  localparam int DW  = 8;
  localparam int ACC = 3;
  localparam int MW  = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_read = 1'b0;
  logic          bus_wait = 1'b0;
  logic [DW-1:0] bus_data = '0;
  logic [DW-1:0] rd_data;
  logic          rd_valid, bus_err, bus_req;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  par_read_master #(.DATA_W(DW), .ACCESS_CYC(ACC), .MAX_WAIT(MW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_read(cmd_read), .rd_data(rd_data),
    .rd_valid(rd_valid), .bus_err(bus_err), .bus_req(bus_req),
    .bus_wait(bus_wait), .bus_data(bus_data));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 access, 2 stall
  int            m_ph = 0, m_t = 0;
  bit            m_req = 0, m_val = 0, m_err = 0;
  logic [DW-1:0] m_dat = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_t = 0; m_req = 0; m_val = 0; m_err = 0; m_dat = '0;
    end else begin
      m_val = 0; m_err = 0;
      if (m_ph == 0) begin
        if (cmd_read) begin m_ph = 1; m_t = 1; m_req = 1; end
      end else if (m_ph == 1) begin
        if (m_t == ACC) begin
          if (bus_wait) begin m_ph = 2; m_t = 0; end
          else begin m_dat = bus_data; m_val = 1; m_ph = 0; m_req = 0; end
        end else m_t++;
      end else begin
        if (!bus_wait) begin m_dat = bus_data; m_val = 1; m_ph = 0; m_req = 0; end
        else if (m_t + 1 == MW) begin m_err = 1; m_ph = 0; m_req = 0; end
        else m_t++;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(bus_req == m_req, "R1 bus_req vs model", int'(bus_req), int'(m_req));
    chk(rd_valid == m_val, "R4 rd_valid vs model", int'(rd_valid), int'(m_val));
    chk(rd_data == m_dat, "R3 rd_data vs model", int'(rd_data), int'(m_dat));
    chk(bus_err == m_err, "R7 bus_err vs model", int'(bus_err), int'(m_err));
  end

  // one transfer: wait high for indices [wf,wt), data d0 before index ds, d1 from ds on
  task automatic xfer(input int wf, input int wt, input int ds,
                      input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                      input bit cmd_mid, input string tag);
    int exp_done = 0, got = -1, reqcnt;
    bit exp_err = 0, got_err = 0;
    logic [DW-1:0] exp_d, prev_d;
    if (!(ACC >= wf && ACC < wt)) exp_done = ACC;
    else begin
      for (int j = ACC + 1; j <= ACC + MW; j++)
        if (exp_done == 0 && !(j >= wf && j < wt)) exp_done = j;
      if (exp_done == 0) begin exp_done = ACC + MW; exp_err = 1; end
    end
    exp_d = (exp_done >= ds) ? d1 : d0;
    prev_d = rd_data;
    @(negedge clk) cmd_read = 1'b1;
    @(negedge clk) cmd_read = 1'b0;
    reqcnt = bus_req ? 1 : 0;
    for (int k = 1; k <= 40; k++) begin
      bus_wait = (k >= wf && k < wt);
      bus_data = (k >= ds) ? d1 : d0;
      cmd_read = cmd_mid && (k == 2);
      @(negedge clk);
      if (rd_valid || bus_err) begin got = k; got_err = bus_err; break; end
      if (bus_req) reqcnt++;
    end
    cmd_read = 1'b0;
    bus_wait = 1'b0;
    chk(got == exp_done, {tag, " R2/R6 completion edge"}, got, exp_done);
    chk(reqcnt == exp_done, {tag, " R2 request length"}, reqcnt, exp_done);
    chk(got_err == exp_err, {tag, " R7 error vs data"}, int'(got_err), int'(exp_err));
    if (exp_err) chk(rd_data == prev_d, {tag, " R7 data kept"}, int'(rd_data), int'(prev_d));
    else chk(rd_data == exp_d, {tag, " R3 captured word"}, int'(rd_data), int'(exp_d));
    @(negedge clk);
    chk(!rd_valid && !bus_err, {tag, " R4 strobe width"}, int'({rd_valid, bus_err}), 0);
    if (cmd_mid) chk(bus_req == 1'b0, {tag, " R8 mid command ignored"}, int'(bus_req), 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (bus_req || rd_valid || bus_err || rd_data != '0) begin
      fails++;
      $display("FAIL R9 reset state: actual %b%b%b/%0h expected 000/0",
               bus_req, rd_valid, bus_err, rd_data);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    xfer(0, 0, 99, 8'hA5, 8'hA5, 1'b0, "fast");
    xfer(1, 3, 3, 8'h11, 8'h22, 1'b0, "R5 early pulse");
    xfer(2, 6, 5, 8'h00, 8'h3C, 1'b0, "R6 stall");
    xfer(3, 8, 8, 8'h00, 8'h5A, 1'b0, "R7 last edge");
    xfer(1, 100, 0, 8'hEE, 8'hEE, 1'b0, "R7 timeout");
    xfer(0, 0, 0, 8'h77, 8'h77, 1'b1, "R8 busy cmd");
    // R5: wait toggling with no request
    bus_wait = 1'b1;
    repeat (3) @(negedge clk);
    chk(!bus_req && !rd_valid && rd_data == 8'h77, "R5 idle wait ignored",
        int'(rd_data), 8'h77);
    bus_wait = 1'b0;
    // R1: command held high, back-to-back transfers
    bus_data = 8'hC3;
    cmd_read = 1'b1;
    @(negedge clk);
    chk(bus_req == 1'b1, "R1 request raised", int'(bus_req), 1);
    repeat (10) @(negedge clk);
    cmd_read = 1'b0;
    repeat (8) @(negedge clk);
    chk(rd_data == 8'hC3 && !bus_req, "R3 back-to-back data", int'(rd_data), 8'hC3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule